// File: doc/BRIEF.md
# I2S Stereo Audio Delay Line

This block sits in a digital audio path and holds back a stereo I2S stream by a fixed, coarsely selectable number of sample frames, typically so that sound lines up with a video pipeline that takes longer. It receives bit clock, word clock and serial data. It captures each left/right pair into a circular frame memory and sends the pair out again, delayed, on its own serial data output. That output uses the same bit clock and word clock, so a downstream I2S receiver can take it directly.

The delay is picked by a small code input and is the same for both channels. Whenever the code takes a new value, and after reset, the output carries silent frames until the memory holds enough fresh frames to cover the whole delay. Old memory contents are therefore never played. The block has no clock other than the audio bit clock; the word clock is treated as data sampled by it.

The serial stream has no handshake and cannot be stalled. One frame is accepted and one frame is emitted per word-clock period. Because the sender sets the pace, there is no back-pressure in either direction.

Top module: `i2s_delay_line`

## Requirements
- R1: Serial data and word clock are sampled on the rising edge of `bclk`. Word clock low marks the left channel and high marks the right channel. The MSB arrives in the first bit clock after a word-clock transition. Up to `SAMPLE_W` bits per channel are kept, and shorter words are aligned to the MSB.
- R2: The block works with 32, 48 or 64 bit clocks per frame and with words of 16 to `SAMPLE_W` bits that fit in half a frame. No setting tells the block the ratio or the word length.
- R3: The delay D, in frames, equals 2^`STEP_LOG2` × (code + 1) − 1, where the code is `del_code` read as unsigned. With `STEP_LOG2` = 8 this is 255 frames at code 0 and 8191 frames at code 31. Once the mute has ended, the output frame begun at frame boundary j is the input frame completed at boundary j − D.
- R4: Left and right share one delay. Each output channel carries the same channel of the input, never the other one.
- R5: `sdout` changes only on the falling edge of `bclk`. Each output word starts MSB first in the bit slot that follows the word-clock transition, so a receiver samples it on the rising edge. Bits after the stored word are zero.
- R6: A new code is accepted at a frame boundary. Counting from that boundary, exactly D all-zero output frames follow. Then comes the data, starting with the input frame completed at that same boundary.
- R7: From reset until the first left-channel start, `sdout` is zero. The first complete frame then counts as a code change, so D zero frames follow as in R6.
- R8: The code passes through a two-stage synchronizer and is sampled only at frame boundaries. A code that changes and returns before the next boundary does not restart the mute, and neither does an unchanged code.
- R9: The circular memory holds 2^(`CODE_W` + `STEP_LOG2`) frames, with one write pointer advancing once per frame. The largest delay therefore stays correct after the pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Audio bit clock; the only clock of the block |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrclk | input | 1 | Word clock: low for left, high for right |
| sdin | input | 1 | Serial audio data in, MSB first |
| del_code | input | CODE_W | Delay select code |
| sdout | output | 1 | Delayed serial audio data out |

## Verification
The bench looks for an off-by-one in the mute length after a code change and after reset. Such a design would emit one zero frame too many or too few, or would play stale or unwritten memory as the first frame. It runs all three bit-clock ratios, including 16-bit words at 32 clocks per frame. Here the last bit of each word lands on the transition edge, so a capture stage that drops that slot loses the LSB, and one that shifts by a slot corrupts every word. It pulses the code between boundaries and keeps it unchanged across many of them; a design that samples the code early or re-arms the mute on every boundary would fall silent. A long run at the largest delay wraps the write pointer, which exposes wrong modulo arithmetic on the read address.

// File: rtl/i2sdl_pkg.sv
package i2sdl_pkg;
  // Channel encoding follows the word clock level.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/i2sdl_rx.sv
module i2sdl_rx
  import i2sdl_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          lrclk,
  input  logic          sdin,
  output logic          half_start,
  output chan_e         half_ch,
  output logic          frame_wr,
  output logic          synced,
  output logic [2*SW-1:0] frame_data
);
  localparam int NBW = $clog2(SW + 1);

  chan_e          lr_q;
  logic           sync_q;
  logic [NBW-1:0] nbit;
  logic [SW-1:0]  sh;
  logic [SW-1:0]  left_q;

  logic           take;
  logic           edge_now;
  logic [SW-1:0]  mask;
  logic [SW-1:0]  sh_nx;

  always_comb begin
    take     = (nbit < NBW'(SW));
    mask     = take ? (SW'(1) << (NBW'(SW - 1) - nbit)) : '0;
    sh_nx    = sdin ? (sh | mask) : sh;
    edge_now = (chan_e'(lrclk) != lr_q);
  end

  assign half_start = edge_now;
  assign half_ch    = chan_e'(lrclk);
  // A falling word clock closes the right word and with it the frame.
  assign frame_wr   = edge_now && (chan_e'(lrclk) == CH_LEFT) && sync_q;
  assign frame_data = {left_q, sh_nx};
  assign synced     = sync_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= CH_LEFT;
      sync_q <= 1'b0;
      nbit   <= '0;
      sh     <= '0;
      left_q <= '0;
    end else begin
      lr_q <= chan_e'(lrclk);
      if (edge_now) begin
        sh   <= '0;
        nbit <= '0;
        if (chan_e'(lrclk) == CH_RIGHT && sync_q) left_q <= sh_nx;
        if (chan_e'(lrclk) == CH_LEFT) sync_q <= 1'b1;
      end else begin
        sh   <= sh_nx;
        nbit <= nbit + NBW'(take);
      end
    end
  end
endmodule

// File: rtl/i2sdl_ctrl.sv
module i2sdl_ctrl
  import i2sdl_pkg::*;
#(
  parameter int CODE_W    = 5,
  parameter int STEP_LOG2 = 6,
  localparam int AW       = CODE_W + STEP_LOG2
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] del_code,
  input  logic              frame_wr,
  output logic              mute_now,
  output logic [AW-1:0]     delay_frames,
  output logic [AW-1:0]     fill_level
);
  logic [SYNC_STAGES-1:0][CODE_W-1:0] sync_chain;
  logic [CODE_W-1:0] code_s;
  logic [CODE_W-1:0] code_q;
  logic              cfg_ok;
  logic [AW-1:0]     fill;
  logic              differs;

  assign code_s       = sync_chain[SYNC_STAGES-1];
  assign delay_frames = {code_q, {STEP_LOG2{1'b1}}};
  assign differs      = !cfg_ok || (code_s != code_q);
  assign mute_now     = differs || (fill < delay_frames);
  assign fill_level   = fill;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_chain <= '0;
    end else begin
      sync_chain[0] <= del_code;
      for (int i = 1; i < SYNC_STAGES; i++) sync_chain[i] <= sync_chain[i-1];
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cfg_ok <= 1'b0;
      fill   <= '0;
    end else if (frame_wr) begin
      if (differs) begin
        code_q <= code_s;
        cfg_ok <= 1'b1;
        fill   <= AW'(1);
      end else if (fill < delay_frames) begin
        fill <= fill + AW'(1);
      end
    end
  end
endmodule

// File: rtl/i2sdl_store.sv
module i2sdl_store #(
  parameter int AW = 11,
  parameter int FW = 48
) (
  input  logic          bclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  input  logic [AW-1:0] delay_frames,
  output logic [FW-1:0] rd_data,
  output logic [AW-1:0] wptr
);
  localparam int DEPTH = 1 << AW;

  logic [FW-1:0] mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rd_addr;
  logic [FW-1:0] rd_q;

  assign rd_addr = wp - delay_frames;
  assign rd_data = rd_q;
  assign wptr    = wp;

  always_ff @(posedge bclk) begin
    if (wr_en) mem[wp] <= wr_data;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)     wp <= '0;
    else if (wr_en) wp <= wp + AW'(1);
  end
endmodule

// File: rtl/i2sdl_tx.sv
module i2sdl_tx
  import i2sdl_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic            bclk,
  input  logic            rst_n,
  input  logic            half_start,
  input  chan_e           half_ch,
  input  logic            frame_wr,
  input  logic            mute_now,
  input  logic [2*SW-1:0] rd_frame,
  output logic            sdout,
  output logic [SW-1:0]   tx_sh
);
  logic [SW-1:0] sh;
  logic [SW-1:0] rhold;
  logic          sdout_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      rhold <= '0;
    end else if (half_start) begin
      if (half_ch == CH_LEFT) begin
        if (frame_wr && !mute_now) begin
          sh    <= rd_frame[2*SW-1:SW];
          rhold <= rd_frame[SW-1:0];
        end else begin
          sh    <= '0;
          rhold <= '0;
        end
      end else begin
        sh <= rhold;
      end
    end else begin
      sh <= {sh[SW-2:0], 1'b0};
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sdout_q <= 1'b0;
    else        sdout_q <= sh[SW-1];
  end

  assign sdout = sdout_q;
  assign tx_sh = sh;
endmodule

// File: rtl/i2s_delay_line.sv
module i2s_delay_line
  import i2sdl_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int CODE_W    = 5,
  parameter int STEP_LOG2 = 6,
  localparam int AW       = CODE_W + STEP_LOG2
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              sdin,
  input  logic [CODE_W-1:0] del_code,
  output logic              sdout
);
  logic                  half_start;
  chan_e                 half_ch;
  logic                  frame_wr;
  logic                  synced;
  logic [2*SAMPLE_W-1:0] frame_data;
  logic                  mute_now;
  logic [AW-1:0]         delay_frames;
  logic [AW-1:0]         fill_level;
  logic [2*SAMPLE_W-1:0] rd_frame;
  logic [AW-1:0]         wptr;
  logic [SAMPLE_W-1:0]   tx_sh;

  i2sdl_rx #(.SW(SAMPLE_W)) u_rx (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdin(sdin),
    .half_start(half_start), .half_ch(half_ch), .frame_wr(frame_wr),
    .synced(synced), .frame_data(frame_data)
  );

  i2sdl_ctrl #(.CODE_W(CODE_W), .STEP_LOG2(STEP_LOG2)) u_ctrl (
    .bclk(bclk), .rst_n(rst_n), .del_code(del_code), .frame_wr(frame_wr),
    .mute_now(mute_now), .delay_frames(delay_frames), .fill_level(fill_level)
  );

  i2sdl_store #(.AW(AW), .FW(2*SAMPLE_W)) u_store (
    .bclk(bclk), .rst_n(rst_n), .wr_en(frame_wr), .wr_data(frame_data),
    .delay_frames(delay_frames), .rd_data(rd_frame), .wptr(wptr)
  );

  i2sdl_tx #(.SW(SAMPLE_W)) u_tx (
    .bclk(bclk), .rst_n(rst_n), .half_start(half_start), .half_ch(half_ch),
    .frame_wr(frame_wr), .mute_now(mute_now), .rd_frame(rd_frame),
    .sdout(sdout), .tx_sh(tx_sh)
  );
endmodule

// File: rtl/i2sdl_checker.sv
module i2sdl_checker #(
  parameter int AW = 11,
  parameter int SW = 24
) (
  input logic          bclk,
  input logic          rst_n,
  input logic          frame_wr,
  input logic          mute_now,
  input logic          synced,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] delay_frames,
  input logic [AW-1:0] fill_level,
  input logic [SW-1:0] tx_sh
);
  // R9: one memory slot per completed frame
  a_r9_wptr_advance: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_wr |=> (wptr == $past(wptr) + AW'(1)));

  // R9: pointer idle between frames
  a_r9_wptr_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_wr |=> $stable(wptr));

  // R8: delay moves only at a frame boundary
  a_r8_delay_hold: assert property (@(posedge bclk) disable iff (!rst_n)
    !frame_wr |=> $stable(delay_frames));

  // R6: fill counter never passes the active delay
  a_r6_fill_bound: assert property (@(posedge bclk) disable iff (!rst_n)
    fill_level <= delay_frames);

  // R6: a muted boundary loads a silent word
  a_r6_mute_loads_zero: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_wr && mute_now) |=> (tx_sh == '0));

  // R7: nothing but zeros before framing is found
  a_r7_silent_until_sync: assert property (@(posedge bclk) disable iff (!rst_n)
    !synced |-> (tx_sh == '0));

  // R1: frames are only stored once aligned
  a_r1_frame_needs_sync: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_wr |-> synced);
endmodule

bind i2s_delay_line i2sdl_checker #(.AW(AW), .SW(SAMPLE_W)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .frame_wr(frame_wr), .mute_now(mute_now),
  .synced(synced), .wptr(wptr), .delay_frames(delay_frames),
  .fill_level(fill_level), .tx_sh(tx_sh)
);

// File: tb/i2s_delay_line_test.sv
`timescale 1ns/1ps
module i2s_delay_line_test;
  localparam int SW = 24;
  localparam int CW = 5;
  localparam int SL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrclk = 1'b1;
  logic sdin = 1'b0;
  logic [CW-1:0] del_code = '0;
  logic sdout;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int in_l[$];
  int in_r[$];
  int d_cur, c_cur, half_len, wid, ph;
  bit in_tail, out_tail, glitched;

  always #2 clk = ~clk;

  i2s_delay_line #(.SAMPLE_W(SW), .CODE_W(CW), .STEP_LOG2(SL)) uut (
    .bclk(clk), .rst_n(rst_n), .lrclk(lrclk), .sdin(sdin),
    .del_code(del_code), .sdout(sdout)
  );

  function automatic int dly(int code);
    return ((code + 1) << SL) - 1;
  endfunction

  function automatic bit bitof(int w, int n, int p);
    return (p < n) ? bit'((w >> (n - 1 - p)) & 1) : 1'b0;
  endfunction

  task automatic check(bit act, bit exp, string tag, int frame);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sdout=%0d expected %0d (phase %0d frame %0d)",
               tag, act, exp, ph, frame);
    end
  endtask

  task automatic drive_half(bit ch, int word, int expw, string tag, int frame,
                            int chg, int glitch);
    logic [CW-1:0] saved;
    saved = del_code;
    for (int s = 0; s < half_len; s++) begin
      bit eb;
      @(negedge clk);
      lrclk = ch;
      sdin  = (s == 0) ? in_tail : bitof(word, wid, s - 1);
      if (s == 1 && chg >= 0) del_code = CW'(chg);
      if (s == 2 && glitch >= 0) del_code = CW'(glitch);
      if (s == 6 && glitch >= 0) del_code = saved;
      eb = (s == 0) ? out_tail : bitof(expw, wid, s - 1);
      @(posedge clk);
      #1;
      check(sdout, eb, tag, frame);
    end
    in_tail  = bitof(word, wid, half_len - 1);
    out_tail = bitof(expw, wid, half_len - 1);
  endtask

  task automatic run_frame(int chg, int glitch);
    int g, l, r, el, er, msk;
    string tl, tr, extra;
    g   = in_l.size();
    msk = (wid >= 32) ? -1 : ((1 << wid) - 1);
    l   = (ph * 4099 + g * 37 + 5) & msk;
    r   = (~l) & msk;
    in_l.push_back(l);
    in_r.push_back(r);
    extra = (half_len != 32) ? " R2" : "";
    if (d_cur == dly((1 << CW) - 1)) extra = {extra, " R9"};
    if (glitched) extra = {extra, " R8"};
    if (g >= 1 && (g - 1) >= c_cur + d_cur) begin
      el = in_l[g - 1 - d_cur];
      er = in_r[g - 1 - d_cur];
      tl = {"R1 R3 R5", extra};
      tr = {"R4 R3 R5", extra};
    end else begin
      el = 0;
      er = 0;
      tl = (c_cur == 0) ? {"R7", extra} : {"R6", extra};
      tr = tl;
    end
    drive_half(1'b0, l, el, tl, g, chg, glitch);
    drive_half(1'b1, r, er, tr, g, -1, -1);
    if (glitch >= 0) glitched = 1;
    if (chg >= 0) begin
      c_cur = g;
      d_cur = dly(chg);
    end
  endtask

  task automatic start_phase(int ratio, int n, int code);
    half_len = ratio / 2;
    wid      = n;
    ph++;
    in_l.delete();
    in_r.delete();
    glitched = 0;
    @(negedge clk);
    rst_n    = 1'b0;
    lrclk    = 1'b1;
    sdin     = 1'b0;
    del_code = CW'(code);
    repeat (3) @(negedge clk);
    @(posedge clk);
    #1;
    check(sdout, 1'b0, "R7 reset", -1);
    @(negedge clk);
    rst_n    = 1'b1;
    d_cur    = dly(code);
    c_cur    = 0;
    in_tail  = 0;
    out_tail = 0;
    drive_half(1'b1, 0, 0, "R7", -1, -1, -1);
  endtask

  task automatic frames(int count);
    for (int i = 0; i < count; i++) run_frame(-1, -1);
  endtask

  initial begin
    ph = 0;
    // 64 clocks per frame, 24-bit words
    start_phase(64, 24, 0);
    frames(20);
    run_frame(2, -1);
    frames(40);
    run_frame(31, -1);
    frames(300);
    // 48 clocks per frame, code pulse between boundaries
    start_phase(48, 24, 1);
    frames(25);
    run_frame(-1, 6);
    frames(25);
    run_frame(5, -1);
    frames(60);
    // 32 clocks per frame, 16-bit words
    start_phase(32, 16, 3);
    frames(45);
    // 64 clocks per frame, 20-bit words
    start_phase(64, 20, 0);
    frames(20);
    run_frame(1, -1);
    frames(25);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule